// File: doc/BRIEF.md
# Accumulator ALU and Flag Unit

This block holds the working registers of a small 8-bit accumulator machine: an accumulator A, two general registers B and C, and a 16-bit address pair built from a high byte H and a low byte L. Each clock cycle it takes one operation code and one immediate byte. It then updates the registers and four status flags together at the next rising edge. The sequencer decides what to run and owns all memory traffic. This unit only performs arithmetic, shifts, transfers and compares.

The flags are sticky. Carry, overflow and negative change only on the specific events listed below and otherwise hold their value. The zero flag is recomputed from the accumulator after every working operation except a compare. A compare writes zero and negative from the difference of its two operands and leaves the registers untouched. The reset is synchronous and active low. It clears every register and every flag.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low at a rising edge, A, B, C, H, L and the flags Z, N, C, V are all cleared at that edge.
- R2: Add codes 10 (A+B) and 11 (A+C) write the 8-bit wrapped sum to A. When the unsigned sum exceeds 255, both C and V are set. Otherwise C and V keep their values.
- R3: Increment codes 2/4/6 (A/B/C) and decrement codes 3/5/7 (A/B/C) wrap modulo 256. An increment that yields 0x00 sets V and clears N. A decrement that yields 0xFF sets N and clears V. Otherwise N and V keep their values. C is unchanged.
- R4: Codes 8 and 9 increment and decrement the pair {H,L} as one 16-bit value. A result of 0x0000 from the increment sets V and clears N. A result of 0xFFFF from the decrement sets N and clears V.
- R5: Subtract codes 12 (A-B) and 13 (A-C) write the wrapped difference to A. N is set exactly when the minuend is below the subtrahend as unsigned numbers. C and V are unchanged.
- R6: Compare codes 25 (A vs B), 26 (A vs C), 27 (A vs imm), 28 (B vs imm) and 29 (C vs imm) set Z to (first == second) and N to (first < second, unsigned). They leave all registers, C and V unchanged.
- R7: After every code other than a compare or an idle code, Z equals (A == 0) using the new value of A.
- R8: Codes 14 and 15 shift A left and right by one bit, filling with 0. They leave C, N and V unchanged.
- R9: Code 16 clears C and changes no register or other flag, apart from the Z recomputation of R7.
- R10: Transfer codes 17 (A to B), 18 (B to A), 19 (A to C), 20 (C to A), 21 (A to H), 22 (H to A), 23 (A to L) and 24 (L to A) copy the byte. They change no flag other than Z per R7.
- R11: Code 1 loads the immediate byte into A and changes no flag other than Z per R7.
- R12: Codes 0, 30 and 31 are idle: no register and no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_code | input | 5 | Operation selected for this cycle |
| imm | input | 8 | Immediate operand for loads and compares |
| acc | output | 8 | Accumulator A |
| reg_b | output | 8 | Register B |
| reg_c | output | 8 | Register C |
| reg_hl | output | 16 | Pair {H,L}, H in the upper byte |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
Random operation streams weighted toward immediate loads keep moving A across its whole range. This separates a wrap that really happened from a flag that merely stayed set. Directed sequences pin the exact wrap points: 0xFF to 0x00 and back, the pair crossing 0xFFFF, sums of exactly 255 and 256, and equal and unequal compares. These tell sticky holds apart from fresh writes. A compare that follows a zero accumulator shows whether Z comes from the operands or from A. Idle codes and a mid-stream reset show that nothing moves without a working operation.

// File: rtl/acc_alu_pkg.sv
// Shared operation codes and the event record passed from the datapath
// to the flag unit. Assumes a 5-bit operation field.
package acc_alu_pkg;

    localparam int OP_W = 5;
    localparam int NREG = 5;
    localparam int IX_A = 0;
    localparam int IX_B = 1;
    localparam int IX_C = 2;
    localparam int IX_H = 3;
    localparam int IX_L = 4;

    typedef enum logic [OP_W-1:0] {
        OP_IDLE   = 5'd0,
        OP_LDI_A  = 5'd1,
        OP_INC_A  = 5'd2,
        OP_DEC_A  = 5'd3,
        OP_INC_B  = 5'd4,
        OP_DEC_B  = 5'd5,
        OP_INC_C  = 5'd6,
        OP_DEC_C  = 5'd7,
        OP_INC_HL = 5'd8,
        OP_DEC_HL = 5'd9,
        OP_ADD_B  = 5'd10,
        OP_ADD_C  = 5'd11,
        OP_SUB_B  = 5'd12,
        OP_SUB_C  = 5'd13,
        OP_SHL_A  = 5'd14,
        OP_SHR_A  = 5'd15,
        OP_CLR_C  = 5'd16,
        OP_A2B    = 5'd17,
        OP_B2A    = 5'd18,
        OP_A2C    = 5'd19,
        OP_C2A    = 5'd20,
        OP_A2H    = 5'd21,
        OP_H2A    = 5'd22,
        OP_A2L    = 5'd23,
        OP_L2A    = 5'd24,
        OP_CMP_AB = 5'd25,
        OP_CMP_AC = 5'd26,
        OP_CMP_AI = 5'd27,
        OP_CMP_BI = 5'd28,
        OP_CMP_CI = 5'd29
    } op_e;

    // Flag-relevant events raised by one operation.
    typedef struct packed {
        logic idle;      // nothing may change
        logic cmp;       // compare: Z/N from operands
        logic cmp_eq;
        logic cmp_lt;
        logic carry_out; // add overflowed the byte
        logic wrap_up;   // increment reached zero
        logic wrap_dn;   // decrement reached all ones
        logic sub_op;    // subtract: N from borrow
        logic sub_lt;
        logic clr_c;
    } flag_ev_t;

endpackage

// File: rtl/acc_alu_regfile.sv
// Byte register bank with one write enable per register.
// Assumes synchronous active-low reset clearing every entry.
module acc_alu_regfile #(
    parameter int W    = 8,
    parameter int NREG = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NREG-1:0]          we,
    input  logic [NREG-1:0][W-1:0]   wd,
    output logic [NREG-1:0][W-1:0]   q
);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        // Hold or load one register each edge.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= '0;
            else if (we[i])
                q[i] <= wd[i];
        end
    end

endmodule

// File: rtl/acc_alu_datapath.sv
// Combinational datapath: decodes the operation, forms new register
// values with write enables, and reports flag events.
// Assumes the register bank order A, B, C, H, L from the package.
module acc_alu_datapath
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [OP_W-1:0]          op_code,
    input  logic [W-1:0]             imm,
    input  logic [NREG-1:0][W-1:0]   q,
    output logic [NREG-1:0]          we,
    output logic [NREG-1:0][W-1:0]   wd,
    output flag_ev_t                 ev,
    output logic [W-1:0]             a_after
);

    localparam int PW = 2 * W;
    localparam logic [W-1:0]  ONES  = {W{1'b1}};
    localparam logic [PW-1:0] PONES = {PW{1'b1}};

    op_e            op;
    logic [W-1:0]   a, b, c;
    logic [PW-1:0]  pair, pair_up, pair_dn;
    logic [W:0]     sum_ab, sum_ac;
    logic [W-1:0]   cmp_x, cmp_y;

    assign op      = op_e'(op_code);
    assign a       = q[IX_A];
    assign b       = q[IX_B];
    assign c       = q[IX_C];
    assign pair    = {q[IX_H], q[IX_L]};
    assign pair_up = pair + 1'b1;
    assign pair_dn = pair - 1'b1;
    assign sum_ab  = {1'b0, a} + {1'b0, b};
    assign sum_ac  = {1'b0, a} + {1'b0, c};

    // Pick the two compare operands.
    always_comb begin
        cmp_x = a;
        cmp_y = imm;
        unique case (op)
            OP_CMP_AB: cmp_y = b;
            OP_CMP_AC: cmp_y = c;
            OP_CMP_BI: cmp_x = b;
            OP_CMP_CI: cmp_x = c;
            default: ;
        endcase
    end

    // Decode the operation into writes and flag events.
    always_comb begin
        we         = '0;
        wd         = q;
        ev         = '0;
        ev.cmp_eq  = (cmp_x == cmp_y);
        ev.cmp_lt  = (cmp_x < cmp_y);
        case (op)
            OP_LDI_A: begin we[IX_A] = 1'b1; wd[IX_A] = imm; end
            OP_INC_A: begin
                we[IX_A] = 1'b1; wd[IX_A] = a + 1'b1;
                ev.wrap_up = (a == ONES);
            end
            OP_DEC_A: begin
                we[IX_A] = 1'b1; wd[IX_A] = a - 1'b1;
                ev.wrap_dn = (a == '0);
            end
            OP_INC_B: begin
                we[IX_B] = 1'b1; wd[IX_B] = b + 1'b1;
                ev.wrap_up = (b == ONES);
            end
            OP_DEC_B: begin
                we[IX_B] = 1'b1; wd[IX_B] = b - 1'b1;
                ev.wrap_dn = (b == '0);
            end
            OP_INC_C: begin
                we[IX_C] = 1'b1; wd[IX_C] = c + 1'b1;
                ev.wrap_up = (c == ONES);
            end
            OP_DEC_C: begin
                we[IX_C] = 1'b1; wd[IX_C] = c - 1'b1;
                ev.wrap_dn = (c == '0);
            end
            OP_INC_HL: begin
                we[IX_H] = 1'b1; we[IX_L] = 1'b1;
                {wd[IX_H], wd[IX_L]} = pair_up;
                ev.wrap_up = (pair == PONES);
            end
            OP_DEC_HL: begin
                we[IX_H] = 1'b1; we[IX_L] = 1'b1;
                {wd[IX_H], wd[IX_L]} = pair_dn;
                ev.wrap_dn = (pair == '0);
            end
            OP_ADD_B: begin
                we[IX_A] = 1'b1; wd[IX_A] = sum_ab[W-1:0];
                ev.carry_out = sum_ab[W];
            end
            OP_ADD_C: begin
                we[IX_A] = 1'b1; wd[IX_A] = sum_ac[W-1:0];
                ev.carry_out = sum_ac[W];
            end
            OP_SUB_B: begin
                we[IX_A] = 1'b1; wd[IX_A] = a - b;
                ev.sub_op = 1'b1; ev.sub_lt = (a < b);
            end
            OP_SUB_C: begin
                we[IX_A] = 1'b1; wd[IX_A] = a - c;
                ev.sub_op = 1'b1; ev.sub_lt = (a < c);
            end
            OP_SHL_A: begin we[IX_A] = 1'b1; wd[IX_A] = {a[W-2:0], 1'b0}; end
            OP_SHR_A: begin we[IX_A] = 1'b1; wd[IX_A] = {1'b0, a[W-1:1]}; end
            OP_CLR_C: ev.clr_c = 1'b1;
            OP_A2B:   begin we[IX_B] = 1'b1; wd[IX_B] = a; end
            OP_B2A:   begin we[IX_A] = 1'b1; wd[IX_A] = b; end
            OP_A2C:   begin we[IX_C] = 1'b1; wd[IX_C] = a; end
            OP_C2A:   begin we[IX_A] = 1'b1; wd[IX_A] = c; end
            OP_A2H:   begin we[IX_H] = 1'b1; wd[IX_H] = a; end
            OP_H2A:   begin we[IX_A] = 1'b1; wd[IX_A] = q[IX_H]; end
            OP_A2L:   begin we[IX_L] = 1'b1; wd[IX_L] = a; end
            OP_L2A:   begin we[IX_A] = 1'b1; wd[IX_A] = q[IX_L]; end
            OP_CMP_AB, OP_CMP_AC, OP_CMP_AI, OP_CMP_BI, OP_CMP_CI:
                ev.cmp = 1'b1;
            default:  ev.idle = 1'b1;
        endcase
    end

    assign a_after = we[IX_A] ? wd[IX_A] : a;

endmodule

// File: rtl/acc_alu_flags.sv
// Sticky status flags. Each flag holds unless an event from the
// datapath names it. Assumes synchronous active-low reset.
module acc_alu_flags
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  flag_ev_t       ev,
    input  logic [W-1:0]   a_after,
    output logic           z,
    output logic           n,
    output logic           c,
    output logic           v
);

    logic z_nx, n_nx, c_nx, v_nx;

    // Resolve the next value of each flag from this cycle's events.
    always_comb begin
        z_nx = z;
        n_nx = n;
        c_nx = c;
        v_nx = v;
        if (!ev.idle) begin
            z_nx = ev.cmp ? ev.cmp_eq : (a_after == '0);
            if (ev.cmp)          n_nx = ev.cmp_lt;
            else if (ev.sub_op)  n_nx = ev.sub_lt;
            else if (ev.wrap_up) n_nx = 1'b0;
            else if (ev.wrap_dn) n_nx = 1'b1;
            if (ev.clr_c)          c_nx = 1'b0;
            else if (ev.carry_out) c_nx = 1'b1;
            if (ev.carry_out || ev.wrap_up) v_nx = 1'b1;
            else if (ev.wrap_dn)            v_nx = 1'b0;
        end
    end

    // Register the four flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z <= 1'b0; n <= 1'b0; c <= 1'b0; v <= 1'b0;
        end else begin
            z <= z_nx; n <= n_nx; c <= c_nx; v <= v_nx;
        end
    end

endmodule

// File: rtl/acc_alu.sv
// Top of the accumulator ALU: register bank, datapath and flag unit.
// One operation per cycle; results appear after the next rising edge.
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [OP_W-1:0]       op_code,
    input  logic [DATA_W-1:0]     imm,
    output logic [DATA_W-1:0]     acc,
    output logic [DATA_W-1:0]     reg_b,
    output logic [DATA_W-1:0]     reg_c,
    output logic [2*DATA_W-1:0]   reg_hl,
    output logic                  flag_z,
    output logic                  flag_n,
    output logic                  flag_c,
    output logic                  flag_v
);

    logic [NREG-1:0]              we;
    logic [NREG-1:0][DATA_W-1:0]  wd, q;
    flag_ev_t                     ev;
    logic [DATA_W-1:0]            a_after;

    acc_alu_regfile #(.W(DATA_W), .NREG(NREG)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(we), .wd(wd), .q(q)
    );

    acc_alu_datapath #(.W(DATA_W)) u_dp (
        .op_code(op_code), .imm(imm), .q(q),
        .we(we), .wd(wd), .ev(ev), .a_after(a_after)
    );

    acc_alu_flags #(.W(DATA_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .ev(ev), .a_after(a_after),
        .z(flag_z), .n(flag_n), .c(flag_c), .v(flag_v)
    );

    assign acc    = q[IX_A];
    assign reg_b  = q[IX_B];
    assign reg_c  = q[IX_C];
    assign reg_hl = {q[IX_H], q[IX_L]};

endmodule

// File: rtl/acc_alu_chk.sv
// Port-level checker for acc_alu, bound into every instance.
module acc_alu_chk #(
    parameter int DATA_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [4:0]            op_code,
    input logic [DATA_W-1:0]     imm,
    input logic [DATA_W-1:0]     acc,
    input logic [DATA_W-1:0]     reg_b,
    input logic [DATA_W-1:0]     reg_c,
    input logic [2*DATA_W-1:0]   reg_hl,
    input logic                  flag_z,
    input logic                  flag_n,
    input logic                  flag_c,
    input logic                  flag_v
);

    logic is_cmp, is_idle;
    assign is_cmp  = (op_code >= 5'd25) && (op_code <= 5'd29);
    assign is_idle = (op_code == 5'd0) || (op_code >= 5'd30);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (acc == '0 && reg_b == '0 && reg_c == '0 && reg_hl == '0
                    && !flag_z && !flag_n && !flag_c && !flag_v));

    p_add_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 5'd10 && ({1'b0, acc} + {1'b0, reg_b}) > 255)
        |=> (flag_c && flag_v));

    p_inc_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 5'd2 && acc == {DATA_W{1'b1}})
        |=> (acc == '0 && flag_v && !flag_n));

    p_pair_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 5'd9 && reg_hl == '0)
        |=> (reg_hl == {2*DATA_W{1'b1}} && flag_n && !flag_v));

    p_cmp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmp |=> ($stable(acc) && $stable(reg_b) && $stable(reg_c)
                    && $stable(reg_hl) && $stable(flag_c) && $stable(flag_v)));

    p_zero_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_cmp && !is_idle) |=> (flag_z == (acc == '0)));

    p_shift_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 5'd14 || op_code == 5'd15)
        |=> ($stable(flag_c) && $stable(flag_n) && $stable(flag_v)));

    p_clr_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op_code == 5'd16 |=> (!flag_c && $stable(flag_n) && $stable(flag_v)
                              && $stable(acc)));

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        is_idle |=> ($stable(acc) && $stable(reg_b) && $stable(reg_c)
                     && $stable(reg_hl) && $stable(flag_z) && $stable(flag_n)
                     && $stable(flag_c) && $stable(flag_v)));

    // imm is only observed through the outputs it feeds.
    logic unused_imm;
    assign unused_imm = ^imm;

endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_acc_alu.sv
// Self-checking bench: directed wrap corners plus seeded random streams,
// compared every cycle against a reference model built from the brief.
module tb_acc_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op_code = 5'd0;
    logic [7:0]  imm = 8'd0;
    logic [7:0]  acc, reg_b, reg_c;
    logic [15:0] reg_hl;
    logic        flag_z, flag_n, flag_c, flag_v;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // reference state
    logic [7:0] m_a, m_b, m_c, m_h, m_l;
    logic       m_z, m_n, m_c_f, m_v;

    always #2.5 clk = ~clk;

    acc_alu dut (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .imm(imm),
        .acc(acc), .reg_b(reg_b), .reg_c(reg_c), .reg_hl(reg_hl),
        .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c), .flag_v(flag_v)
    );

    function automatic string tag_of(input logic [4:0] op);
        if (op == 0 || op >= 30)   return "R12";
        if (op == 1)               return "R11";
        if (op >= 2 && op <= 7)    return "R3";
        if (op == 8 || op == 9)    return "R4";
        if (op == 10 || op == 11)  return "R2";
        if (op == 12 || op == 13)  return "R5";
        if (op == 14 || op == 15)  return "R8";
        if (op == 16)              return "R9";
        if (op <= 24)              return "R10";
        return "R6";
    endfunction

    task automatic model_reset();
        {m_a, m_b, m_c, m_h, m_l} = '0;
        {m_z, m_n, m_c_f, m_v} = '0;
    endtask

    // Reference step written from the requirement list.
    task automatic model_step(input logic [4:0] op, input logic [7:0] im);
        logic [8:0]  s;
        logic [15:0] p;
        logic [7:0]  x, y;
        p = {m_h, m_l};
        case (op)
            1:  m_a = im;
            2:  begin m_a = m_a + 1; if (m_a == 0) begin m_v = 1; m_n = 0; end end
            3:  begin m_a = m_a - 1; if (m_a == 8'hFF) begin m_n = 1; m_v = 0; end end
            4:  begin m_b = m_b + 1; if (m_b == 0) begin m_v = 1; m_n = 0; end end
            5:  begin m_b = m_b - 1; if (m_b == 8'hFF) begin m_n = 1; m_v = 0; end end
            6:  begin m_c = m_c + 1; if (m_c == 0) begin m_v = 1; m_n = 0; end end
            7:  begin m_c = m_c - 1; if (m_c == 8'hFF) begin m_n = 1; m_v = 0; end end
            8:  begin p = p + 1; if (p == 0) begin m_v = 1; m_n = 0; end
                      {m_h, m_l} = p; end
            9:  begin p = p - 1; if (p == 16'hFFFF) begin m_n = 1; m_v = 0; end
                      {m_h, m_l} = p; end
            10, 11: begin
                s = {1'b0, m_a} + {1'b0, (op == 10) ? m_b : m_c};
                if (s > 255) begin m_c_f = 1; m_v = 1; end
                m_a = s[7:0];
            end
            12, 13: begin
                y = (op == 12) ? m_b : m_c;
                m_n = (m_a < y);
                m_a = m_a - y;
            end
            14: m_a = m_a << 1;
            15: m_a = m_a >> 1;
            16: m_c_f = 0;
            17: m_b = m_a;
            18: m_a = m_b;
            19: m_c = m_a;
            20: m_a = m_c;
            21: m_h = m_a;
            22: m_a = m_h;
            23: m_l = m_a;
            24: m_a = m_l;
            default: ;
        endcase
        if (op >= 25 && op <= 29) begin
            x = (op == 28) ? m_b : (op == 29) ? m_c : m_a;
            y = (op == 25) ? m_b : (op == 26) ? m_c : im;
            m_z = (x == y);
            m_n = (x < y);
        end else if (!(op == 0 || op >= 30)) begin
            m_z = (m_a == 0); // R7
        end
    endtask

    task automatic compare(input string tag);
        logic [43:0] got, exp;
        got = {acc, reg_b, reg_c, reg_hl, flag_z, flag_n, flag_c, flag_v};
        exp = {m_a, m_b, m_c, m_h, m_l, m_z, m_n, m_c_f, m_v};
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h (A B C HL ZNCV)", tag, got, exp);
        end
    endtask

    // Drive one operation, let it take effect, then check at the falling edge.
    task automatic run_op(input logic [4:0] op, input logic [7:0] im);
        op_code = op;
        imm = im;
        @(posedge clk);
        model_step(op, im);
        @(negedge clk);
        compare(tag_of(op));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        op_code = 5'd0;
        repeat (2) @(posedge clk);
        model_reset();
        @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
    endtask

    initial begin
        int seed;
        seed = 32'h5EED_1234;
        void'($urandom(seed));
        @(negedge clk);
        // R1: reset clears all state
        do_reset();
        // R11 / R3: A wraps upward then back down
        run_op(5'd1, 8'hFF);
        run_op(5'd2, 8'h00);   // R3 inc wrap: V=1 N=0 Z=1
        run_op(5'd3, 8'h00);   // R3 dec wrap: N=1 V=0
        run_op(5'd3, 8'h00);   // R3 no wrap: N,V held
        // R4: pair crossing 0xFFFF both ways
        run_op(5'd1, 8'hFF);
        run_op(5'd21, 8'h00);  // R10
        run_op(5'd23, 8'h00);
        run_op(5'd8, 8'h00);   // R4 -> 0000, V set
        run_op(5'd9, 8'h00);   // R4 -> FFFF, N set
        // R2: sums of 255 and 256
        run_op(5'd16, 8'h00);  // R9
        run_op(5'd1, 8'h01);
        run_op(5'd17, 8'h00);
        run_op(5'd1, 8'hFE);
        run_op(5'd10, 8'h00);  // R2: 255, no carry
        run_op(5'd10, 8'h00);  // R2: 256, carry and overflow
        // R5: borrow then no borrow
        run_op(5'd1, 8'h05);
        run_op(5'd19, 8'h00);
        run_op(5'd1, 8'h03);
        run_op(5'd13, 8'h00);  // R5: 3-5 negative
        run_op(5'd1, 8'h09);
        run_op(5'd13, 8'h00);  // R5: 9-5 non-negative
        // R6: compare against zero accumulator
        run_op(5'd1, 8'h00);
        run_op(5'd27, 8'h07);  // R6: Z=0 though A==0
        run_op(5'd27, 8'h00);  // R6: equal
        run_op(5'd28, 8'h02);  // R6: B vs imm
        // R8: shifts fill with zero
        run_op(5'd1, 8'h81);
        run_op(5'd14, 8'h00);
        run_op(5'd1, 8'h81);
        run_op(5'd15, 8'h00);
        // R12: idle codes
        run_op(5'd31, 8'hAA);
        run_op(5'd30, 8'h55);
        run_op(5'd0, 8'h12);
        // Random stream, weighted to immediate loads
        for (int i = 0; i < 4000; i++) begin
            logic [4:0] op;
            op = ($urandom % 4 == 0) ? 5'd1 : 5'($urandom % 32);
            run_op(op, 8'($urandom));
            if (i == 2000) do_reset(); // R1 mid-stream
        end
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(5ns * 100000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule